// File: doc/BRIEF.md
# Clock Output Configuration Register Bank

This block holds the per-output configuration for a bank of eight clock outputs. Each output has one 32-bit register. The register carries a 2-bit path-select mode, an enable, an 8-bit divide code and a 4-bit delay code. Software-side logic writes and reads the bank through a flat address/data port with a write strobe. The decoded fields of every register are presented in parallel to the divider bank.

Register 0 also holds a self-clearing global reset bit. A write that sets it discards its other bits. One cycle later, all eight registers return to their power-on values and the bit reads as zero again. A pulse output flags every clock edge at which any divide code changed, so that a later stage can schedule an output alignment.

Top module: `clk_out_cfg_bank`

## Requirements
- R1: After rst_ni is released, every register 0..7 reads 0x0000_0100: mode 0, enable 0, divide code 1, delay code 0.
- R2: Field positions are as follows. Delay code is at bits 7:4, divide code at bits 15:8, enable at bit 16 and mode at bits 18:17. Mode codes are 0 bypass, 1 divided, 2 delayed and 3 divided plus delayed. They are stored as written. A write to register n changes only register n.
- R3: Bits 3:0 and 30:19 always read as zero. Bit 31 reads as zero in registers 1..7.
- R4: Writes to addresses 8 and above change nothing, and reads from those addresses return zero.
- R5: A write to register 0 with bit 31 set leaves every register unchanged and drops the other bits of that write. In the following cycle only, bit 31 of register 0 reads as 1. After that, register 0 can be programmed again with bit 31 clear.
- R6: At the clock edge after the reset write, all eight registers take their R1 values, and bit 31 of register 0 then reads as 0.
- R7: A write presented in the cycle in which the global reset completes is dropped.
- R8: div_chg_o is high for exactly the one cycle that follows a clock edge at which some divide code changed value, whether by a write or by the global reset. It stays low for writes that keep every divide code the same.
- R9: Output n drives mode_o[2n+:2], en_o[n], div_o[8n+:8] and dly_o[4n+:4]. Each of these always equals the matching field of register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| mode_o | output | 16 | Mode field per output |
| en_o | output | 8 | Enable per output |
| div_o | output | 64 | Divide code per output |
| dly_o | output | 32 | Delay code per output |
| div_chg_o | output | 1 | One-cycle pulse after any divide code change |

## Verification
The bench writes every address from 0 to 15 with several arithmetic patterns and reads back the full address space and every parallel output after each write. A decode that aliases address 8 and above onto the bank, or that leaks bits into the reserved range, shows up as a mismatch in the readback. The bench sets the reset bit with all other bits at one and pushes a write in the following cycle. A design that let the other bits through would corrupt register 0. One that acted on the queued write would leave register 3 off its default. A bit that did not clear itself would still read as 1. The divide-change pulse is checked after writes that keep the divide code, after writes that change it, and after the global reset. A pulse that stuck high or fired on enable-only edits would be caught.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned DLY_W  = 4;

  localparam int unsigned DLY_LSB  = 4;
  localparam int unsigned DIV_LSB  = 8;
  localparam int unsigned EN_BIT   = 16;
  localparam int unsigned MODE_LSB = 17;
  localparam int unsigned GRST_BIT = 31;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              en;
    logic [DIV_W-1:0]  div;
    logic [DLY_W-1:0]  dly;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{mode: '0, en: 1'b0, div: DIV_W'(1), dly: '0};

  function automatic cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.mode = w[MODE_LSB +: MODE_W];
    c.en   = w[EN_BIT];
    c.div  = w[DIV_LSB +: DIV_W];
    c.dly  = w[DLY_LSB +: DLY_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_pack(input cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MODE_LSB +: MODE_W] = c.mode;
    w[EN_BIT]             = c.en;
    w[DIV_LSB +: DIV_W]   = c.div;
    w[DLY_LSB +: DLY_W]   = c.dly;
    return w;
  endfunction
endpackage

// File: rtl/clk_cfg_slot.sv
module clk_cfg_slot
  import clk_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic              div_chg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (clr_i)     cfg_d = CFG_DEFAULT;
    else if (wr_i) cfg_d = cfg_unpack(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_DEFAULT;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign div_chg_o = (cfg_d.div != cfg_q.div);

  AST_CLR_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cfg_q == CFG_DEFAULT)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_i) |=> $stable(cfg_q)); // R4
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && wr_i) |=> (cfg_q.div == DIV_W'(1))); // R7
endmodule

// File: rtl/clk_cfg_grst.sv
module clk_cfg_grst
  import clk_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= !pend_q && wr_en_i && (addr_i == '0) && wdata_i[GRST_BIT];
  end

  assign pend_o = pend_q;

  AST_GRST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q); // R6
  AST_GRST_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && wr_en_i && addr_i == '0 && wdata_i[GRST_BIT]) |=> pend_q); // R5
endmodule

// File: rtl/clk_cfg_rdmux.sv
module clk_cfg_rdmux
  import clk_cfg_pkg::*;
#(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  cfg_t              cfg_i [N_OUT],
  input  logic              pend_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  always_comb begin
    rdata_o = '0;
    if (32'(addr_i) < N_OUT) begin
      rdata_o = cfg_pack(cfg_i[addr_i[IDX_W-1:0]]);
      if (addr_i == '0) rdata_o[GRST_BIT] = pend_i;
    end
  end
endmodule

// File: rtl/clk_out_cfg_bank.sv
module clk_out_cfg_bank
  import clk_cfg_pkg::*;
#(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [N_OUT*MODE_W-1:0] mode_o,
  output logic [N_OUT-1:0]        en_o,
  output logic [N_OUT*DIV_W-1:0]  div_o,
  output logic [N_OUT*DLY_W-1:0]  dly_o,
  output logic                    div_chg_o
);
  localparam logic [DATA_W-1:0] RSVD_MASK = 32'h7FF8_000F;

  cfg_t             cfg [N_OUT];
  logic [N_OUT-1:0] chg;
  logic             pend;
  logic             div_chg_q;

  clk_cfg_grst #(.ADDR_W(ADDR_W)) u_grst (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .pend_o(pend)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_slot
    logic wr;
    if (n == 0) begin : g_r0
      assign wr = wr_en_i && (addr_i == ADDR_W'(n)) && !wdata_i[GRST_BIT] && !pend;
    end else begin : g_rn
      assign wr = wr_en_i && (addr_i == ADDR_W'(n)) && !pend;
    end

    clk_cfg_slot u_slot (
      .clk_i, .rst_ni, .wr_i(wr), .clr_i(pend), .wdata_i,
      .cfg_o(cfg[n]), .div_chg_o(chg[n])
    );

    assign mode_o[n*MODE_W +: MODE_W] = cfg[n].mode;
    assign en_o[n]                    = cfg[n].en;
    assign div_o[n*DIV_W +: DIV_W]    = cfg[n].div;
    assign dly_o[n*DLY_W +: DLY_W]    = cfg[n].dly;
  end

  clk_cfg_rdmux #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_rdmux (
    .cfg_i(cfg), .pend_i(pend), .addr_i, .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_chg_q <= 1'b0;
    else         div_chg_q <= |chg;
  end

  assign div_chg_o = div_chg_q;

  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) >= N_OUT) |-> (rdata_o == '0)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & RSVD_MASK) == '0)); // R3
  AST_NO_PULSE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_chg_o |-> (div_o == $past(div_o))); // R8
  AST_PULSE_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_chg_o |-> (div_o != $past(div_o))); // R8
endmodule

// File: tb/clk_out_cfg_bank_tb.sv
module clk_out_cfg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] mode_o;
  logic [7:0]  en_o;
  logic [63:0] div_o;
  logic [31:0] dly_o;
  logic        div_chg;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_out_cfg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mode_o(mode_o), .en_o(en_o), .div_o(div_o), .dly_o(dly_o),
    .div_chg_o(div_chg)
  );

  function automatic logic [31:0] keep(input logic [31:0] w);
    return w & 32'h0007_FFF0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) begin
      addr = 4'(i);
      #1;
      check(req, rdata, (i < N) ? m[i] : 32'h0);  // R3 R4
    end
    for (int n = 0; n < N; n++) begin
      check("R9 mode", 32'(mode_o[n*2 +: 2]), 32'(m[n][18:17]));
      check("R9 en",   32'(en_o[n]),          32'(m[n][16]));
      check("R9 div",  32'(div_o[n*8 +: 8]),  32'(m[n][15:8]));
      check("R9 dly",  32'(dly_o[n*4 +: 4]),  32'(m[n][7:4]));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
    logic exp_chg;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    exp_chg = (a < N) && (m[a][15:8] != d[15:8]);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < N) m[a] = keep(d);
    check({req, " R8 pulse"}, 32'(div_chg), 32'(exp_chg));
  endtask

  initial begin
    for (int n = 0; n < N; n++) m[n] = 32'h0000_0100;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 pulse idle", 32'(div_chg), 0);
    check_all("R1 defaults");

    // R2 R4 sweeps over the full address range
    for (int r = 0; r < 3; r++) begin
      for (int a = 0; a < 16; a++) begin
        wr(4'(a), (32'(a) * 32'h9E37_79B1 + 32'(r) * 32'h7F4A_7C15) & 32'h7FFF_FFFF, "R2");
        check_all("R2 readback");
      end
    end

    // R8: enable-only edit, then divide edit, then pulse drops
    wr(4'd2, m[2] ^ 32'h0001_0000, "R8 same div");
    wr(4'd2, m[2] ^ 32'h0000_0300, "R8 new div");
    @(negedge clk);
    check("R8 single cycle", 32'(div_chg), 0);

    // R5 R6 R7 global reset with a queued write
    begin
      logic any_div;
      logic [31:0] r0_old;
      any_div = 1'b0;
      for (int n = 0; n < N; n++) if (m[n][15:8] != 8'd1) any_div = 1'b1;
      r0_old = m[0];
      @(negedge clk);
      wr_en = 1'b1; addr = 4'd0; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      #1;
      check("R5 bit31 pending", rdata, r0_old | 32'h8000_0000);
      check("R5 no pulse", 32'(div_chg), 0);
      addr = 4'd3; wdata = 32'h0005_5550;  // R7 queued write
      @(negedge clk);
      wr_en = 1'b0;
      check("R8 pulse on reset", 32'(div_chg), 32'(any_div));
      for (int n = 0; n < N; n++) m[n] = 32'h0000_0100;
      check_all("R6 R7 defaults");
      addr = 4'd0; #1;
      check("R6 bit31 cleared", rdata, 32'h0000_0100);
    end

    wr(4'd0, 32'h0006_A5B0, "R5 reprogram");
    check_all("R5 reprogram");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule